// File: doc/BRIEF.md
# Debug Register Access Controller

This block keeps the debug register set that a core consults when it arms breakpoints. There are four breakpoint address registers, one status register and one control register. The core reaches them by a 3-bit index. Indices 0 to 3 select the address registers, 6 selects status and 7 selects control. Indices 4 and 5 are legacy names: they reach status and control, unless the core's debug-extension input is set. With that input set, those two indices are illegal.

Each request is accepted on a valid/ready handshake. It is answered exactly one cycle later with read data and a one-hot fault vector. The block enforces three access rules. An aliased index is illegal when extensions are on. A general-detect bit in control turns the next access into a trap that disarms itself. A status or control write that sets any reserved bit is refused. The current address, status and control values are always driven out for a neighbouring breakpoint comparator.

Top module: `dbg_reg_ctrl`

## Requirements
- R1: After reset, status reads 0xFFFF0FF0, control reads 0x400, all four address registers read 0, no response is pending, and req_ready_o is high from the first clock after reset.
- R2: An accepted request gets rsp_valid_o high for exactly the following cycle. rsp_fault_o is one-hot or zero, with bit 0 = invalid opcode, bit 1 = general protection, bit 2 = debug trap. Bit 1 always carries error code 0.
- R3: A fault-free write to index 0..3 stores all XLEN bits into that address register, with no reserved-bit check. The new value is visible on bp_addr_o (slice index*XLEN) from the cycle after acceptance.
- R4: With dbg_ext_i low, index 4 acts as index 6 and index 5 acts as index 7, for both reads and writes.
- R5: With dbg_ext_i high, an access to index 4 or 5 raises the invalid-opcode fault, returns 0 and changes no register.
- R6: If control bit 13 (general detect) is set, any access raises the debug trap, clears control bit 13, sets status bit 13, returns 0 and performs no write.
- R7: A write to status or control whose data has a bit set under RSVD_MASK (default: bits 63..32) raises the general-protection fault and leaves every register unchanged.
- R8: A committed status write stores the data ORed with 0xFFFF0FF0.
- R9: A committed control write stores the data ORed with 0x400 (bit 10).
- R10: Priority is invalid opcode, then debug trap, then general protection. An illegal alias with general detect set leaves bit 13 of control set. A reserved-bit write with general detect set traps and writes nothing.
- R11: A fault-free read returns the addressed register's value before that cycle's update. Any faulting access, and every write, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 3 | Register index 0..7 |
| req_wdata_i | input | XLEN | Write data |
| dbg_ext_i | input | 1 | Debug extensions enabled (indices 4/5 illegal) |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | XLEN | Read data, 0 on fault or write |
| rsp_fault_o | output | 3 | One-hot fault: {debug trap, GP, invalid opcode} |
| bp_addr_o | output | 4*XLEN | Breakpoint address registers, index 0 in low slice |
| dr_stat_o | output | XLEN | Current status register |
| dr_ctrl_o | output | XLEN | Current control register |

## Verification
The hardest case to reach is two rules colliding on one access. An illegal alias and a reserved-bit write must each be issued while general detect is armed. Arming it takes a committed control write with bit 13, and every trap disarms it. The stimulus therefore re-arms general detect before each collision. It first rewrites status to clear the earlier detect flag, so that "unchanged" can be seen on dr_stat_o. A read is used as a trigger too, to show that reads consume the armed state as well as writes.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int NUM_BP         = 4;
  localparam int IDX_W          = 3;
  localparam int STAT_BD_BIT    = 13;
  localparam int CTRL_GD_BIT    = 13;
  localparam int CTRL_FIXED_BIT = 10;
  localparam logic [31:0] STAT_FIXED32 = 32'hFFFF_0FF0;

  typedef struct packed {
    logic db;  // bit 2
    logic gp;  // bit 1
    logic ud;  // bit 0
  } dbg_fault_t;
endpackage

// File: rtl/dbg_idx_decode.sv
module dbg_idx_decode
  import dbg_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ext_i,
  output logic [IDX_W-1:0] eff_idx_o,
  output logic             ud_o
);
  logic legacy;

  assign legacy = idx_i[2] & ~idx_i[1];  // 4 or 5

  always_comb begin
    eff_idx_o = idx_i;
    if (legacy && !ext_i) eff_idx_o = {2'b11, idx_i[0]};
  end

  assign ud_o = legacy & ext_i;
endmodule

// File: rtl/dbg_access_check.sv
module dbg_access_check
  import dbg_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RSVD_MASK = ~XLEN'(32'hFFFF_FFFF)
) (
  input  logic            write_i,
  input  logic            sc_sel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            ud_i,
  input  logic            gd_i,
  output dbg_fault_t      fault_o
);
  logic rsvd_hit;

  assign rsvd_hit = |(wdata_i & RSVD_MASK);

  // priority: ud > db > gp
  always_comb begin
    fault_o    = '0;
    fault_o.ud = ud_i;
    fault_o.db = gd_i & ~ud_i;
    fault_o.gp = write_i & sc_sel_i & rsvd_hit & ~ud_i & ~gd_i;
  end
endmodule

// File: rtl/dbg_reg_file.sv
module dbg_reg_file
  import dbg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acc_i,
  input  logic                   write_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [XLEN-1:0]        wdata_i,
  input  dbg_fault_t             fault_i,
  output logic [NUM_BP*XLEN-1:0] bp_o,
  output logic [XLEN-1:0]        stat_o,
  output logic [XLEN-1:0]        ctrl_o,
  output logic [XLEN-1:0]        rdata_o
);
  localparam logic [XLEN-1:0] STAT_RST = XLEN'(STAT_FIXED32);
  localparam logic [XLEN-1:0] CTRL_RST = XLEN'(1) << CTRL_FIXED_BIT;

  logic [XLEN-1:0] bp_q [NUM_BP];
  logic [XLEN-1:0] stat_q, ctrl_q;
  logic            commit;

  assign commit = acc_i & write_i & (fault_i == '0);

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             bp_q[g] <= '0;
      else if (commit && idx_i == IDX_W'(g))   bp_q[g] <= wdata_i;
    end
    assign bp_o[g*XLEN +: XLEN] = bp_q[g];

    // R3
    bp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit && idx_i == IDX_W'(g) |=> bp_q[g] == $past(wdata_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST;
      ctrl_q <= CTRL_RST;
    end else if (acc_i && fault_i.db) begin
      ctrl_q[CTRL_GD_BIT] <= 1'b0;
      stat_q[STAT_BD_BIT] <= 1'b1;
    end else if (commit && idx_i == IDX_W'(6)) begin
      stat_q <= wdata_i | STAT_RST;
    end else if (commit && idx_i == IDX_W'(7)) begin
      ctrl_q <= wdata_i | CTRL_RST;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BP; i++)
      if (idx_i == IDX_W'(i)) rdata_o = bp_q[i];
    if (idx_i == IDX_W'(6)) rdata_o = stat_q;
    if (idx_i == IDX_W'(7)) rdata_o = ctrl_q;
  end

  assign stat_o = stat_q;
  assign ctrl_o = ctrl_q;

  // R6
  gd_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && fault_i.db |=> !ctrl_q[CTRL_GD_BIT] && stat_q[STAT_BD_BIT]);

  // R5
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (fault_i.ud || fault_i.gp) |=> $stable(stat_q) && $stable(ctrl_q) && $stable(bp_o));

  // R8
  stat_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & STAT_RST) == STAT_RST);

  // R9
  ctrl_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CTRL_FIXED_BIT]);
endmodule

// File: rtl/dbg_reg_ctrl.sv
module dbg_reg_ctrl
  import dbg_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RSVD_MASK = ~XLEN'(32'hFFFF_FFFF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [2:0]             req_idx_i,
  input  logic [XLEN-1:0]        req_wdata_i,
  input  logic                   dbg_ext_i,
  output logic                   rsp_valid_o,
  output logic [XLEN-1:0]        rsp_rdata_o,
  output logic [2:0]             rsp_fault_o,
  output logic [4*XLEN-1:0]      bp_addr_o,
  output logic [XLEN-1:0]        dr_stat_o,
  output logic [XLEN-1:0]        dr_ctrl_o
);
  logic             ready_q, acc;
  logic [IDX_W-1:0] eff_idx;
  logic             ud, gd;
  dbg_fault_t       fault;
  logic [XLEN-1:0]  rd_val;
  logic             rsp_valid_q;
  logic [XLEN-1:0]  rsp_rdata_q;
  dbg_fault_t       rsp_fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign req_ready_o = ready_q;
  assign acc         = req_valid_i & ready_q;
  assign gd          = dr_ctrl_o[CTRL_GD_BIT];

  dbg_idx_decode u_dec (
    .idx_i     (req_idx_i),
    .ext_i     (dbg_ext_i),
    .eff_idx_o (eff_idx),
    .ud_o      (ud)
  );

  dbg_access_check #(.XLEN(XLEN), .RSVD_MASK(RSVD_MASK)) u_chk (
    .write_i  (req_write_i),
    .sc_sel_i (eff_idx[2] & eff_idx[1]),
    .wdata_i  (req_wdata_i),
    .ud_i     (ud),
    .gd_i     (gd),
    .fault_o  (fault)
  );

  dbg_reg_file #(.XLEN(XLEN)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .write_i (req_write_i),
    .idx_i   (eff_idx),
    .wdata_i (req_wdata_i),
    .fault_i (fault),
    .bp_o    (bp_addr_o),
    .stat_o  (dr_stat_o),
    .ctrl_o  (dr_ctrl_o),
    .rdata_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_fault_q <= '0;
    end else begin
      rsp_valid_q <= acc;
      rsp_fault_q <= acc ? fault : '0;
      rsp_rdata_q <= (acc && !req_write_i && fault == '0) ? rd_val : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_fault_o = rsp_fault_q;

  // R2
  rsp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  // R2
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);

  // R2
  fault_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_fault_o));

  // R10
  ud_over_gd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ud && gd |=> dr_ctrl_o[CTRL_GD_BIT] && rsp_fault_o == 3'b001);

  // R11
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o != 3'b000 |-> rsp_rdata_o == '0);
endmodule

// File: tb/tb_dbg_reg_ctrl.sv
module tb_dbg_reg_ctrl;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0, dbg_ext = 1'b0;
  logic [2:0]      req_idx = '0;
  logic [XLEN-1:0] req_wdata = '0;
  logic            req_ready, rsp_valid;
  logic [XLEN-1:0] rsp_rdata, dr_stat, dr_ctrl;
  logic [2:0]      rsp_fault;
  logic [4*XLEN-1:0] bp_addr;

  int checks = 0, errors = 0;
  logic            r_valid;
  logic [XLEN-1:0] r_data;
  logic [2:0]      r_fault;

  always #2.5 clk = ~clk;

  dbg_reg_ctrl #(.XLEN(XLEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_idx_i(req_idx), .req_wdata_i(req_wdata),
    .dbg_ext_i(dbg_ext),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_fault_o(rsp_fault),
    .bp_addr_o(bp_addr), .dr_stat_o(dr_stat), .dr_ctrl_o(dr_ctrl)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] idx, input logic [XLEN-1:0] d, input logic ext);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = d; dbg_ext = ext;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; dbg_ext = 1'b0;
    r_valid = rsp_valid; r_data = rsp_rdata; r_fault = rsp_fault;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 stat", dr_stat, 64'hFFFF_0FF0);
    chk("R1 ctrl", dr_ctrl, 64'h400);
    chk("R1 bp", bp_addr[XLEN-1:0] | bp_addr[XLEN +: XLEN] | bp_addr[2*XLEN +: XLEN] | bp_addr[3*XLEN +: XLEN], '0);
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 ready", 64'(req_ready), 1);
  endtask

  task automatic t_timing;
    access(1'b0, 3'd6, '0, 1'b0);
    chk("R2 rsp_valid after accept", 64'(r_valid), 1);
    chk("R2 no fault", 64'(r_fault), 0);
    @(negedge clk);
    chk("R2 rsp_valid one cycle", 64'(rsp_valid), 0);
  endtask

  task automatic t_bp_write;
    for (int i = 0; i < 4; i++) begin
      logic [XLEN-1:0] v;
      v = 64'hA5A5_0000_0000_1000 ^ (64'(i) << 56) ^ 64'(i * 8);
      access(1'b1, 3'(i), v, 1'b0);
      chk("R3 write fault", 64'(r_fault), 0);
      chk("R11 write rdata zero", r_data, 0);
      chk("R3 bp_addr slice", bp_addr[i*XLEN +: XLEN], v);
      access(1'b0, 3'(i), '0, 1'b0);
      chk("R11 readback", r_data, v);
    end
  endtask

  task automatic t_stat_ctrl;
    access(1'b1, 3'd6, 64'h0000_000F, 1'b0);
    chk("R8 stat or-fixed", dr_stat, 64'hFFFF_0FFF);
    access(1'b1, 3'd7, 64'h0000_00FF, 1'b0);
    chk("R9 ctrl or-fixed", dr_ctrl, 64'h4FF);
    access(1'b0, 3'd7, '0, 1'b0);
    chk("R11 ctrl read", r_data, 64'h4FF);
  endtask

  task automatic t_alias;
    access(1'b1, 3'd5, 64'h3, 1'b0);
    chk("R4 alias 5->7 write", dr_ctrl, 64'h403);
    chk("R4 alias fault", 64'(r_fault), 0);
    access(1'b0, 3'd4, '0, 1'b0);
    chk("R4 alias 4->6 read", r_data, 64'hFFFF_0FFF);
  endtask

  task automatic t_ud;
    access(1'b1, 3'd5, 64'h55, 1'b1);
    chk("R5 ud fault", 64'(r_fault), 64'b001);
    chk("R5 ctrl unchanged", dr_ctrl, 64'h403);
    access(1'b0, 3'd4, '0, 1'b1);
    chk("R5 ud read fault", 64'(r_fault), 64'b001);
    chk("R5 ud rdata", r_data, 0);
    access(1'b0, 3'd6, '0, 1'b1);
    chk("R5 ext leaves idx6 legal", r_data, 64'hFFFF_0FFF);
  endtask

  task automatic t_gp;
    access(1'b1, 3'd7, 64'h1_0000_0000, 1'b0);
    chk("R7 ctrl gp fault", 64'(r_fault), 64'b010);
    chk("R7 ctrl unchanged", dr_ctrl, 64'h403);
    access(1'b1, 3'd6, 64'h8000_0000_0000_0000, 1'b0);
    chk("R7 stat gp fault", 64'(r_fault), 64'b010);
    chk("R7 stat unchanged", dr_stat, 64'hFFFF_0FFF);
    access(1'b1, 3'd2, 64'hFFFF_FFFF_0000_0002, 1'b0);
    chk("R3 no rsvd check on bp", bp_addr[2*XLEN +: XLEN], 64'hFFFF_FFFF_0000_0002);
  endtask

  task automatic t_gd;
    logic [XLEN-1:0] bp0;
    bp0 = bp_addr[XLEN-1:0];
    access(1'b1, 3'd6, '0, 1'b0);
    access(1'b1, 3'd7, 64'h2000, 1'b0);
    chk("R9 gd armed", dr_ctrl, 64'h2400);
    access(1'b1, 3'd0, 64'h1234, 1'b0);
    chk("R6 db fault", 64'(r_fault), 64'b100);
    chk("R6 no write", bp_addr[XLEN-1:0], bp0);
    chk("R6 gd cleared", dr_ctrl, 64'h0400);
    chk("R6 bd set", dr_stat, 64'hFFFF_2FF0);
    access(1'b1, 3'd0, 64'h1234, 1'b0);
    chk("R6 next access ok", bp_addr[XLEN-1:0], 64'h1234);
    access(1'b1, 3'd7, 64'h2000, 1'b0);
    access(1'b0, 3'd1, '0, 1'b0);
    chk("R6 read traps", 64'(r_fault), 64'b100);
    chk("R6 read rdata zero", r_data, 0);
    chk("R6 read clears gd", dr_ctrl, 64'h0400);
  endtask

  task automatic t_prio;
    access(1'b1, 3'd6, '0, 1'b0);
    access(1'b1, 3'd7, 64'h2000, 1'b0);
    access(1'b0, 3'd4, '0, 1'b1);
    chk("R10 ud wins", 64'(r_fault), 64'b001);
    chk("R10 gd kept", dr_ctrl, 64'h2400);
    chk("R10 stat kept", dr_stat, 64'hFFFF_0FF0);
    access(1'b1, 3'd7, 64'h1_0000_0001, 1'b0);
    chk("R10 db over gp", 64'(r_fault), 64'b100);
    chk("R10 ctrl not written", dr_ctrl, 64'h0400);
  endtask

  initial begin
    #(5.0 * 20000);
    checks++; errors++;
    $display("FAIL watchdog R2 got=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_bp_write();
    t_stat_ctrl();
    t_alias();
    t_ud();
    t_gp();
    t_gd();
    t_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule